// File: doc/BRIEF.md
# Channel DC Offset Correction and Calibration Engine

This block conditions the instantaneous sample stream of a single measurement channel. Each signed input sample is summed with a programmable DC offset and scaled by a programmable gain, and the corrected result leaves the block one clock later, clamped to the 24-bit range. A chip with several channels instantiates the block once per channel. Each instance keeps its own offset, gain and cycle-count state, so calibrating one channel cannot disturb another.

On a start command the engine runs a DC offset calibration. It first lets 30 valid samples pass as settling time. It then sums the next N valid raw input samples, where N is a power of two chosen through the cycle-count register. It takes the floor of their mean with an arithmetic shift and loads the negated mean into the offset register. While the sequence runs, the gain used on the output path is forced to unity, and the stored gain register is left as it was. Completion sets a sticky ready flag, and a mask bit routes that flag to an interrupt line.

Top module: `chan_dcofs_cal`

## Requirements
- R1: When `sample_vld` is high in a cycle, the next cycle shows `corr_vld` high and `corr_out` = floor(((sample + offset) × gain) / 2^22). Here the sample and offset are signed 24-bit values and the gain is unsigned 24-bit, with 0x400000 meaning 1.0. A cycle without `sample_vld` gives `corr_vld` low in the next cycle and leaves `corr_out` unchanged.
- R2: A corrected value above 0x7FFFFF is output as 0x7FFFFF. A value below -0x800000 is output as 0x800000.
- R3: After an accepted start, the first 30 valid samples are discarded. The next N = 2^k valid samples are accumulated, where k is register address 2, bits 3:0, as captured at the start.
- R4: At completion, the offset register (address 0) receives the negation of floor(sum / N). If that negation would be +2^23, the register receives 0x7FFFFF instead.
- R5: While a calibration is in progress, `corr_out` uses a gain of exactly 1.0. The gain register (address 1) keeps its programmed value throughout.
- R6: A start command received while a calibration is in progress is ignored. It neither restarts settling nor clears the accumulation.
- R7: Completion sets the ready flag (address 3, bit 0). The flag stays set until a register write to address 3 has bit 0 equal to one. A write with bit 0 equal to zero leaves it set.
- R8: `irq` is high exactly when the ready flag and the mask bit (address 3, bit 1, written with every address-3 write) are both set.
- R9: Register map: address 0 is the offset, address 1 is the gain, address 2 is the cycle exponent k, and address 3 is the status with {mask, ready} in bits 1:0. After reset the offset reads 0, the gain reads 0x400000, and k and the status read 0.
- R10: `cal_busy` rises in the cycle after an accepted start. It falls at the clock edge that loads the new offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Input sample qualifier |
| sample_in | input | 24 | Signed instantaneous sample |
| cal_start | input | 1 | Start a DC offset calibration |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| corr_vld | output | 1 | Corrected sample qualifier |
| corr_out | output | 24 | Corrected, saturated sample |
| cal_busy | output | 1 | Calibration in progress |
| irq | output | 1 | Masked ready interrupt |

## Verification
Some properties are checked on every cycle by the assertions:
- `corr_vld` tracks `sample_vld` one cycle later, and `corr_out` holds when no sample arrives.
- The busy flag rises only after a start command.
- A start received mid-sequence leaves the sample counter untouched.
- The ready flag rises only on an offset load, and it stays set until it is cleared.

Other behaviour can only be shown by the bench's scenarios:
- The arithmetic value of the corrected output across a grid of samples, offsets and gains, including both saturation limits.
- The exact offset produced by calibrations of several lengths, with negative sums that need floor rounding, with the negation clamp, and with a start issued mid-sequence.
- The unity gain forced during calibration.

// File: rtl/chcal_pkg.sv
// Shared constants and types for the channel offset calibration engine.
// Assumes a 2-bit register address space with four registers.
package chcal_pkg;
    localparam logic [1:0] ADDR_OFFSET = 2'd0;
    localparam logic [1:0] ADDR_GAIN   = 2'd1;
    localparam logic [1:0] ADDR_CYCLE  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_SETTLE = 2'd1,
        CAL_ACCUM  = 2'd2
    } cal_state_e;
endpackage

// File: rtl/chcal_regs.sv
// Register file: offset, gain, cycle exponent, sticky ready flag and mask.
// Assumes a calibration load and a software write to the offset do not both
// need to land; when they coincide, the calibration result wins.
module chcal_regs
    import chcal_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int LOG2N_W   = 4,
    parameter int GAIN_FRAC = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ofs_load,
    input  logic [DATA_W-1:0] ofs_value,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] gain,
    output logic [LOG2N_W-1:0] log2n,
    output logic              ready,
    output logic              mask
);
    localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << GAIN_FRAC;

    logic wr_ofs, wr_gain, wr_cyc, wr_stat;

    // Decode the write strobe per register.
    always_comb begin
        wr_ofs  = wr && (addr == ADDR_OFFSET);
        wr_gain = wr && (addr == ADDR_GAIN);
        wr_cyc  = wr && (addr == ADDR_CYCLE);
        wr_stat = wr && (addr == ADDR_STATUS);
    end

    // Offset register: a calibration result overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)        offset <= '0;
        else if (ofs_load) offset <= ofs_value;
        else if (wr_ofs)   offset <= wdata;
    end

    // Gain register, reset to unity.
    always_ff @(posedge clk) begin
        if (!rst_n)       gain <= GAIN_ONE;
        else if (wr_gain) gain <= wdata;
    end

    // Cycle exponent register.
    always_ff @(posedge clk) begin
        if (!rst_n)      log2n <= '0;
        else if (wr_cyc) log2n <= wdata[LOG2N_W-1:0];
    end

    // Interrupt mask bit, rewritten by every status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 1'b0;
        else if (wr_stat) mask <= wdata[1];
    end

    // Sticky ready flag: set on completion, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ready <= 1'b0;
        else if (ofs_load)            ready <= 1'b1;
        else if (wr_stat && wdata[0]) ready <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_OFFSET: rdata = offset;
            ADDR_GAIN:   rdata = gain;
            ADDR_CYCLE:  rdata = DATA_W'(log2n);
            default:     rdata = {{(DATA_W-2){1'b0}}, mask, ready};
        endcase
    end

    // R7: ready only rises on the edge after an offset load.
    assert_ready_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ofs_load));

    // R7: ready holds unless a clearing write arrives.
    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(wr && addr == ADDR_STATUS && wdata[0])) |=> ready);
endmodule

// File: rtl/chcal_seq.sv
// Calibration sequencer: skips the settling samples, sums N = 2^k raw
// samples, and produces the negated floor mean as the new offset.
// Assumes the accumulator width DATA_W + 2^LOG2N_W - 1 covers the largest N.
module chcal_seq
    import chcal_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int LOG2N_W  = 4,
    parameter int SETTLE_N = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cal_start,
    input  logic               sample_vld,
    input  logic [DATA_W-1:0]  sample_in,
    input  logic [LOG2N_W-1:0] log2n,
    output logic               cal_busy,
    output logic               ofs_load,
    output logic [DATA_W-1:0]  ofs_value
);
    localparam int EXTRA_W   = (2 ** LOG2N_W) - 1;
    localparam int ACC_W     = DATA_W + EXTRA_W;
    localparam int SETTLE_CW = $clog2(SETTLE_N + 1);
    localparam int CNT_W     = (EXTRA_W + 1 > SETTLE_CW) ? EXTRA_W + 1 : SETTLE_CW;
    localparam logic signed [ACC_W-1:0] NEG_HI =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};

    cal_state_e                state_q;
    logic [CNT_W-1:0]          cnt_q;
    logic signed [ACC_W-1:0]   acc_q;
    logic [LOG2N_W-1:0]        log2_q;

    logic signed [ACC_W-1:0]   sample_ext, acc_next, avg_s, neg_s;
    logic [CNT_W-1:0]          n_last;
    logic                      last_settle, last_accum;

    // Sum, mean and end-of-phase detection for the current cycle.
    always_comb begin
        sample_ext  = ACC_W'($signed(sample_in));
        acc_next    = acc_q + sample_ext;
        n_last      = (CNT_W'(1) << log2_q) - CNT_W'(1);
        last_settle = (state_q == CAL_SETTLE) && sample_vld && (cnt_q == CNT_W'(SETTLE_N - 1));
        last_accum  = (state_q == CAL_ACCUM) && sample_vld && (cnt_q == n_last);
        avg_s       = acc_next >>> log2_q;
        neg_s       = -avg_s;
        ofs_value   = (neg_s > NEG_HI) ? OUT_HI : neg_s[DATA_W-1:0];
        ofs_load    = last_accum;
        cal_busy    = (state_q != CAL_IDLE);
    end

    // Phase state, sample counter, accumulator and captured exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
            log2_q  <= '0;
        end else begin
            case (state_q)
                CAL_IDLE: begin
                    if (cal_start) begin
                        state_q <= (SETTLE_N == 0) ? CAL_ACCUM : CAL_SETTLE;
                        cnt_q   <= '0;
                        acc_q   <= '0;
                        log2_q  <= log2n;
                    end
                end
                CAL_SETTLE: begin
                    if (sample_vld) begin
                        if (last_settle) begin
                            state_q <= CAL_ACCUM;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                CAL_ACCUM: begin
                    if (sample_vld) begin
                        acc_q <= acc_next;
                        if (last_accum) begin
                            state_q <= CAL_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    // R10: busy only rises after a start command.
    assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> $past(cal_start));

    // R6: a start while busy and without a sample leaves the count untouched.
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && cal_start && !sample_vld) |=> (cal_busy && $stable(cnt_q) && $stable(acc_q)));

    // R3: the accumulation count never passes N-1.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_ACCUM) |-> (cnt_q <= n_last));
endmodule

// File: rtl/chcal_datapath.sv
// Correction path: (sample + offset) * gain, rescaled and clamped, one
// register stage. Assumes gain is unsigned with GAIN_FRAC fraction bits.
module chcal_datapath #(
    parameter int DATA_W    = 24,
    parameter int GAIN_FRAC = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [DATA_W-1:0] offset,
    input  logic [DATA_W-1:0] gain,
    input  logic              force_unity,
    output logic              corr_vld,
    output logic [DATA_W-1:0] corr_out
);
    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = 2 * DATA_W + 2;
    localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << GAIN_FRAC;
    localparam logic signed [PROD_W-1:0] SAT_HI =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SAT_LO = ~SAT_HI;
    localparam logic [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] OUT_LO = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [SUM_W-1:0]  sum_s;
    logic [DATA_W-1:0]        gain_eff;
    logic signed [PROD_W-1:0] prod_s, scaled_s;
    logic [DATA_W-1:0]        sat_v;

    // Offset add, gain multiply, rescale and clamp.
    always_comb begin
        sum_s    = $signed({sample_in[DATA_W-1], sample_in}) + $signed({offset[DATA_W-1], offset});
        gain_eff = force_unity ? GAIN_ONE : gain;
        prod_s   = PROD_W'(sum_s) * PROD_W'($signed({1'b0, gain_eff}));
        scaled_s = prod_s >>> GAIN_FRAC;
        if (scaled_s > SAT_HI)      sat_v = OUT_HI;
        else if (scaled_s < SAT_LO) sat_v = OUT_LO;
        else                        sat_v = scaled_s[DATA_W-1:0];
    end

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_vld <= 1'b0;
            corr_out <= '0;
        end else begin
            corr_vld <= sample_vld;
            if (sample_vld) corr_out <= sat_v;
        end
    end

    // R1: output qualifier follows the input qualifier by one cycle.
    assert_vld_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> corr_vld);

    // R1: no input sample means no output sample and a held value.
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> (!corr_vld && $stable(corr_out)));
endmodule

// File: rtl/chan_dcofs_cal.sv
// Top level of the per-channel DC offset correction and calibration engine.
// Assumes one instance per channel; all state is private to the instance.
module chan_dcofs_cal
    import chcal_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int LOG2N_W  = 4,
    parameter int SETTLE_N = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              cal_start,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              corr_vld,
    output logic [DATA_W-1:0] corr_out,
    output logic              cal_busy,
    output logic              irq
);
    localparam int GAIN_FRAC = DATA_W - 2;

    logic [DATA_W-1:0]  offset, gain, ofs_value;
    logic [LOG2N_W-1:0] log2n;
    logic               ready, mask, ofs_load;

    chcal_regs #(.DATA_W(DATA_W), .LOG2N_W(LOG2N_W), .GAIN_FRAC(GAIN_FRAC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .ofs_load(ofs_load), .ofs_value(ofs_value), .rdata(reg_rdata),
        .offset(offset), .gain(gain), .log2n(log2n), .ready(ready), .mask(mask)
    );

    chcal_seq #(.DATA_W(DATA_W), .LOG2N_W(LOG2N_W), .SETTLE_N(SETTLE_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .sample_vld(sample_vld),
        .sample_in(sample_in), .log2n(log2n), .cal_busy(cal_busy),
        .ofs_load(ofs_load), .ofs_value(ofs_value)
    );

    chcal_datapath #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_dp (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
        .offset(offset), .gain(gain), .force_unity(cal_busy),
        .corr_vld(corr_vld), .corr_out(corr_out)
    );

    // Masked interrupt.
    always_comb irq = ready && mask;
endmodule

// File: tb/sim_chan_dcofs_cal.sv
`timescale 1ns/1ps
module sim_chan_dcofs_cal;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [23:0] sample_in = '0;
    logic        cal_start = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        corr_vld;
    logic [23:0] corr_out;
    logic        cal_busy;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic mask_now = 1'b0;

    chan_dcofs_cal u0 (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
        .cal_start(cal_start), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .corr_vld(corr_vld),
        .corr_out(corr_out), .cal_busy(cal_busy), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint clamp(input longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint model_corr(input longint s, input longint o, input longint g);
        longint p;
        p = (s + o) * g;
        return clamp(p >>> 22);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input longint d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d[23:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output longint d);
        reg_addr = a;
        #0.5;
        d = longint'(reg_rdata);
    endtask

    task automatic feed(input longint s);
        @(negedge clk);
        sample_vld = 1'b1; sample_in = s[23:0];
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    // One calibration with preset offset 1000 and gain 0x200000.
    task automatic run_cal(input int k, input longint base, input bit mid_start);
        longint sum, v, s, rd, expo;
        int n;
        n = 1 << k;
        sum = 0;
        wr_reg(2'd0, 1000);
        wr_reg(2'd2, k);
        pulse_start();
        check("R10 busy after start", cal_busy, 1);
        for (int i = 0; i < 30; i++) begin
            s = 4000000 + i * 11;
            feed(s);
            check("R5 unity gain while settling", sx(corr_out), clamp(s + 1000));
        end
        for (int j = 0; j < n; j++) begin
            if (mid_start && j == 3) begin
                pulse_start();
                check("R6 busy kept on repeated start", cal_busy, 1);
            end
            v = base + j * 37 - (j % 3) * 1000;
            if (v < -8388608) v = -8388608;
            sum += v;
            if (j < n - 1) begin
                feed(v);
                check("R5 unity gain while accumulating", sx(corr_out), clamp(v + 1000));
            end else begin
                feed(v);
            end
        end
        check("R10 busy low after load", cal_busy, 0);
        expo = -(sum >>> k);
        if (expo > 8388607) expo = 8388607;
        rd_reg(2'd0, rd);
        check(mid_start ? "R6 offset after ignored start" : "R3 R4 calibrated offset", sx(rd[23:0]), expo);
        rd_reg(2'd1, rd);
        check("R5 gain register kept", rd, 64'h200000);
        rd_reg(2'd2, rd);
        check("R9 cycle exponent readback", rd, k);
        rd_reg(2'd3, rd);
        check("R7 ready set", rd & 1, 1);
        check("R8 irq follows mask", irq, mask_now);
        wr_reg(2'd3, {mask_now, 1'b1});
        rd_reg(2'd3, rd);
        check("R7 ready cleared by one", rd & 1, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        longint rd;
        longint offs [5] = '{0, 1000, -5000, 8388607, -8388608};
        longint gns  [5] = '{64'h400000, 64'h200000, 64'h7FFFFF, 0, 64'h600000};
        longint smp  [9] = '{0, 1, -1, 12345, -12345, 8388607, -8388608, 3000000, -3000000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset values
        rd_reg(2'd0, rd); check("R9 offset reset", rd, 0);
        rd_reg(2'd1, rd); check("R9 gain reset", rd, 64'h400000);
        rd_reg(2'd2, rd); check("R9 cycle reset", rd, 0);
        rd_reg(2'd3, rd); check("R9 status reset", rd, 0);
        check("R1 no output after reset", corr_vld, 0);
        check("R10 idle after reset", cal_busy, 0);
        check("R8 irq low after reset", irq, 0);

        // R1/R2 sweep of the correction path
        foreach (offs[oi]) begin
            wr_reg(2'd0, offs[oi]);
            foreach (gns[gi]) begin
                wr_reg(2'd1, gns[gi]);
                foreach (smp[si]) begin
                    longint e, raw;
                    raw = ((smp[si] + offs[oi]) * gns[gi]) >>> 22;
                    e = clamp(raw);
                    feed(smp[si]);
                    check((raw != e) ? "R2 clamp" : "R1 corrected value", sx(corr_out), e);
                    check("R1 output valid", corr_vld, 1);
                end
            end
        end
        @(negedge clk);
        check("R1 valid drops with input", corr_vld, 0);

        // Calibrations with mask off, then on
        wr_reg(2'd1, 64'h200000);
        mask_now = 1'b0;
        wr_reg(2'd3, 0);
        run_cal(1, 123457, 1'b0);
        run_cal(2, -777777, 1'b0);
        mask_now = 1'b1;
        wr_reg(2'd3, 2);
        run_cal(3, 5, 1'b1);
        run_cal(4, -3, 1'b0);
        run_cal(0, -8388608, 1'b0);
        run_cal(0, 42, 1'b0);

        // R7 a zero write keeps ready; R8 mask gating
        run_cal(2, 100, 1'b0);
        wr_reg(2'd0, 0);
        wr_reg(2'd3, 0);
        pulse_start();
        for (int i = 0; i < 34; i++) feed(-8);
        rd_reg(2'd0, rd);
        check("R4 offset from constant input", sx(rd[23:0]), 8);
        wr_reg(2'd3, 0);
        rd_reg(2'd3, rd);
        check("R7 zero write keeps ready", rd & 1, 1);
        check("R8 irq low with mask clear", irq, 0);
        wr_reg(2'd3, 2);
        check("R8 irq high with mask set", irq, 1);
        wr_reg(2'd3, 3);
        check("R8 irq low after clear", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule